// File: doc/BRIEF.md
# Bit-Serial CRC Remainder Engine

This block keeps a running CRC remainder over a serial bit stream. It takes one data bit per clock, least significant bit of each byte first, and updates the remainder in reflected form: the register shifts right and the polynomial constant is folded in whenever the feedback bit is set. The polynomial and the preset value are inputs, so one engine can produce the USB/IBM checksum (reflected constant 0xA001) and the CCITT checksum (reflected constant 0x8408), both starting from 0xFFFF.

A second, narrower remainder register runs alongside the wide one for USB token packets. It uses the low bits of the same polynomial, preset and residue inputs. A select input chooses which remainder is shown. A comparator flags when the shown remainder equals a supplied residue value. The receiver uses this flag to accept a frame once the transmitted, complemented check bits have also been shifted through.

Top module: `serial_crc_engine`

## Requirements
- R1: During synchronous active-low reset both remainder registers are cleared to zero, so `crc_o` reads 0 after reset.
- R2: A high `clear_i` at a clock edge loads `preset_i` into the wide remainder and `preset_i[4:0]` into the narrow remainder, visible after that edge.
- R3: When `clear_i` and `bit_vld_i` are both high at the same edge, the preset is loaded and the data bit is discarded.
- R4: With `clear_i` and `bit_vld_i` both low, both remainders keep their value whatever `bit_i`, `poly_i` and `preset_i` do.
- R5: Each edge with `bit_vld_i` high and `clear_i` low consumes exactly one bit: f = rem[0] XOR `bit_i`, then rem becomes (rem >> 1) XOR (f ? poly : 0).
- R6: With poly 0xA001 and preset 0xFFFF, the ASCII bytes "123456789" sent LSB first give 0x4B37. With poly 0x8408 they give 0x6F91.
- R7: With `mode_short_i` = 1, `crc_o[4:0]` shows the 5-bit remainder, which uses `poly_i[4:0]`, and `crc_o[15:5]` reads zero. With `mode_short_i` = 0, `crc_o` shows the 16-bit remainder.
- R8: `residue_ok_o` is high in the same cycle exactly when the shown remainder equals `residue_i`. In 5-bit mode only `residue_i[4:0]` is compared.
- R9: With poly 0xA001 and preset 0xFFFF, shifting data and then the complement of its 16-bit remainder (LSB first) leaves 0xB001.
- R10: In 5-bit mode with poly 0x14 and preset 0x1F, shifting data and then the complement of its 5-bit remainder (LSB first) leaves 0x06.
- R11: Both remainders advance on every accepted bit whatever `mode_short_i` is, so changing the select mid-stream shows a remainder that has seen every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Load preset into both remainders |
| bit_vld_i | input | 1 | Consume `bit_i` this cycle |
| bit_i | input | 1 | Serial data bit |
| mode_short_i | input | 1 | 1 shows the 5-bit remainder, 0 the 16-bit remainder |
| poly_i | input | 16 | Reflected polynomial constant (low 5 bits drive the narrow lane) |
| preset_i | input | 16 | Preset value (low 5 bits drive the narrow lane) |
| residue_i | input | 16 | Expected residue for the comparator |
| crc_o | output | 16 | Shown remainder |
| residue_ok_o | output | 1 | Shown remainder equals the residue |

## Verification
The bench loads a clear together with a valid bit. A design that gave the bit priority would leave a shifted preset instead of the new one. It drives bits with the valid strobe low, where a design that ignored the strobe would drift. It checks the first two shifts by hand with feedback both clear and set, which catches a left shift or a swapped feedback bit. It also runs the published check vectors and the 16-bit and 5-bit residue checks with complemented check bits, together with a mid-stream change of mode: a design that updated only the shown lane, or compared the full residue in 5-bit mode, would report wrong values there.

// File: rtl/scrc_pkg.sv
// Shared definitions for the serial CRC engine.
// Assumes: the narrow lane is never wider than the wide lane.
package scrc_pkg;
    localparam int unsigned WIDE_W_DEF  = 16;
    localparam int unsigned SHORT_W_DEF = 5;

    // Which remainder the output view presents.
    typedef enum logic {
        SEL_WIDE  = 1'b0,
        SEL_SHORT = 1'b1
    } lane_sel_e;
endpackage

// File: rtl/scrc_lfsr_lane.sv
// One right-shifting reflected-form remainder register.
// Consumes one serial bit per step; load wins over step.
// Assumes: poly_i/seed_i are held stable by the user while in use.
module scrc_lfsr_lane #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         bit_i,
    input  logic [W-1:0] poly_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_nxt;
    logic         fb;

    // Next remainder for one consumed bit.
    always_comb begin
        fb      = rem_q[0] ^ bit_i;
        rem_nxt = {1'b0, rem_q[W-1:1]} ^ (fb ? poly_i : '0);
    end

    // Remainder register: reset, preset load, or one shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= seed_i;
        end else if (step_i) begin
            rem_q <= rem_nxt;
        end
    end

    assign rem_o = rem_q;
endmodule

// File: rtl/scrc_view.sv
// Output selection and residue comparison.
// Presents the chosen remainder zero-extended and compares it against
// the residue input, masked to the narrow width in short mode.
module scrc_view
    import scrc_pkg::*;
#(
    parameter int unsigned WIDE_W  = 16,
    parameter int unsigned SHORT_W = 5
) (
    input  lane_sel_e          sel_i,
    input  logic [WIDE_W-1:0]  rem_wide_i,
    input  logic [SHORT_W-1:0] rem_short_i,
    input  logic [WIDE_W-1:0]  residue_i,
    output logic [WIDE_W-1:0]  view_o,
    output logic               match_o
);
    localparam int unsigned PAD_W = WIDE_W - SHORT_W;

    logic [WIDE_W-1:0] target;

    // Pick the shown remainder and its comparison target.
    always_comb begin
        if (sel_i == SEL_SHORT) begin
            view_o = {{PAD_W{1'b0}}, rem_short_i};
            target = {{PAD_W{1'b0}}, residue_i[SHORT_W-1:0]};
        end else begin
            view_o = rem_wide_i;
            target = residue_i;
        end
        match_o = (view_o == target);
    end
endmodule

// File: rtl/serial_crc_engine.sv
// Bit-serial CRC engine with a wide lane and an optional narrow lane.
// Both lanes see every accepted bit; mode_short_i only picks the view.
// Assumes: synchronous active-low reset; clear has priority over valid.
module serial_crc_engine
    import scrc_pkg::*;
#(
    parameter int unsigned WIDE_W    = WIDE_W_DEF,
    parameter int unsigned SHORT_W   = SHORT_W_DEF,
    parameter bit          HAS_SHORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              mode_short_i,
    input  logic [WIDE_W-1:0] poly_i,
    input  logic [WIDE_W-1:0] preset_i,
    input  logic [WIDE_W-1:0] residue_i,
    output logic [WIDE_W-1:0] crc_o,
    output logic              residue_ok_o
);
    logic [WIDE_W-1:0]  rem_wide;
    logic [SHORT_W-1:0] rem_short;
    logic               step;
    lane_sel_e          sel;

    // A bit is taken only when no clear is pending.
    assign step = bit_vld_i & ~clear_i;
    assign sel  = mode_short_i ? SEL_SHORT : SEL_WIDE;

    scrc_lfsr_lane #(.W(WIDE_W)) u_wide (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (clear_i),
        .step_i (step),
        .bit_i  (bit_i),
        .poly_i (poly_i),
        .seed_i (preset_i),
        .rem_o  (rem_wide)
    );

    // Narrow lane exists only when the parameter asks for it.
    generate
        if (HAS_SHORT) begin : g_short
            scrc_lfsr_lane #(.W(SHORT_W)) u_short (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (clear_i),
                .step_i (step),
                .bit_i  (bit_i),
                .poly_i (poly_i[SHORT_W-1:0]),
                .seed_i (preset_i[SHORT_W-1:0]),
                .rem_o  (rem_short)
            );
        end else begin : g_no_short
            assign rem_short = '0;
        end
    endgenerate

    scrc_view #(.WIDE_W(WIDE_W), .SHORT_W(SHORT_W)) u_view (
        .sel_i       (sel),
        .rem_wide_i  (rem_wide),
        .rem_short_i (rem_short),
        .residue_i   (residue_i),
        .view_o      (crc_o),
        .match_o     (residue_ok_o)
    );
endmodule

// File: rtl/scrc_checker.sv
// Property checker for serial_crc_engine, attached with bind.
// Observes ports plus the two lane remainders.
module scrc_checker #(
    parameter int unsigned WIDE_W  = 16,
    parameter int unsigned SHORT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear_i,
    input logic               bit_vld_i,
    input logic               bit_i,
    input logic               mode_short_i,
    input logic [WIDE_W-1:0]  poly_i,
    input logic [WIDE_W-1:0]  preset_i,
    input logic [WIDE_W-1:0]  residue_i,
    input logic [WIDE_W-1:0]  crc_o,
    input logic               residue_ok_o,
    input logic [WIDE_W-1:0]  rem_wide,
    input logic [SHORT_W-1:0] rem_short
);
    // R2 and R3: clear loads the preset, even alongside a valid bit.
    p_clear_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> rem_wide == $past(preset_i));

    // R4: no strobe, no change in either lane.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !bit_vld_i) |=> ($stable(rem_wide) && $stable(rem_short)));

    // R5: with clear feedback a zero enters the top bit.
    p_nofb_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && !clear_i && (rem_wide[0] == bit_i)) |=> rem_wide[WIDE_W-1] == 1'b0);

    // R5: with set feedback the top bit takes the polynomial top bit.
    p_fb_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && !clear_i && (rem_wide[0] != bit_i)) |=> rem_wide[WIDE_W-1] == $past(poly_i[WIDE_W-1]));

    // R7: the upper output bits are zero in 5-bit mode.
    p_short_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_short_i |-> crc_o[WIDE_W-1:SHORT_W] == '0);

    // R8: a match persists while nothing moves.
    p_match_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (residue_ok_o && !clear_i && !bit_vld_i) ##1 ($stable(residue_i) && $stable(mode_short_i)) |-> residue_ok_o);
endmodule

bind serial_crc_engine scrc_checker #(.WIDE_W(WIDE_W), .SHORT_W(SHORT_W)) u_scrc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .bit_vld_i    (bit_vld_i),
    .bit_i        (bit_i),
    .mode_short_i (mode_short_i),
    .poly_i       (poly_i),
    .preset_i     (preset_i),
    .residue_i    (residue_i),
    .crc_o        (crc_o),
    .residue_ok_o (residue_ok_o),
    .rem_wide     (rem_wide),
    .rem_short    (rem_short)
);

// File: tb/tb_serial_crc_engine.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_serial_crc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        mode_short_i = 1'b0;
    logic [15:0] poly_i = 16'h0;
    logic [15:0] preset_i = 16'h0;
    logic [15:0] residue_i = 16'h0;
    logic [15:0] crc_o;
    logic        residue_ok_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench-side models of both remainders.
    logic [15:0] m16;
    logic [15:0] m5;

    always #2 clk = ~clk;

    serial_crc_engine dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .bit_vld_i    (bit_vld_i),
        .bit_i        (bit_i),
        .mode_short_i (mode_short_i),
        .poly_i       (poly_i),
        .preset_i     (preset_i),
        .residue_i    (residue_i),
        .crc_o        (crc_o),
        .residue_ok_o (residue_ok_o)
    );

    function automatic logic [15:0] ref_step(logic [15:0] r, logic b, logic [15:0] p);
        logic f;
        f = r[0] ^ b;
        return (r >> 1) ^ (f ? p : 16'h0);
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_clear(input logic [15:0] pre);
        preset_i = pre;
        clear_i  = 1'b1;
        @(negedge clk);
        clear_i  = 1'b0;
        m16 = pre;
        m5  = {11'h0, pre[4:0]};
    endtask

    task automatic send_bit(input logic b);
        bit_i     = b;
        bit_vld_i = 1'b1;
        @(negedge clk);
        bit_vld_i = 1'b0;
        m16 = ref_step(m16, b, poly_i);
        m5  = ref_step(m5, b, {11'h0, poly_i[4:0]});
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic t_reset;
        residue_i = 16'h0000;
        chk("R1", "crc after reset", crc_o, 16'h0000);
        chk("R8", "match of zero residue after reset", {15'h0, residue_ok_o}, 16'h1);
    endtask

    task automatic t_step;
        poly_i = 16'hA001;
        do_clear(16'hFFFF);
        chk("R2", "preset loaded", crc_o, 16'hFFFF);
        send_bit(1'b1);
        chk("R5", "first bit, feedback clear", crc_o, 16'h7FFF);
        send_bit(1'b0);
        chk("R5", "second bit, feedback set", crc_o, 16'h9FFE);
    endtask

    task automatic t_hold;
        do_clear(16'h1234);
        bit_i = 1'b1;
        preset_i = 16'hAAAA;
        poly_i = 16'h5555;
        repeat (3) @(negedge clk);
        chk("R4", "idle strobes keep remainder", crc_o, 16'h1234);
    endtask

    task automatic t_clear_wins;
        poly_i   = 16'hA001;
        preset_i = 16'hBEEF;
        clear_i  = 1'b1;
        bit_vld_i = 1'b1;
        bit_i    = 1'b1;
        @(negedge clk);
        clear_i  = 1'b0;
        bit_vld_i = 1'b0;
        chk("R3", "clear beats valid", crc_o, 16'hBEEF);
    endtask

    task automatic t_vectors;
        string s;
        s = "123456789";
        poly_i = 16'hA001;
        do_clear(16'hFFFF);
        for (int i = 0; i < 9; i++) send_byte(s[i]);
        chk("R6", "0xA001 check vector", crc_o, 16'h4B37);
        poly_i = 16'h8408;
        do_clear(16'hFFFF);
        for (int i = 0; i < 9; i++) send_byte(s[i]);
        chk("R6", "0x8408 check vector", crc_o, 16'h6F91);
    endtask

    task automatic t_residue16;
        logic [15:0] c;
        poly_i = 16'hA001;
        residue_i = 16'hB001;
        do_clear(16'hFFFF);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        c = m16;
        chk("R5", "data remainder", crc_o, c);
        chk("R8", "match before check bits", {15'h0, residue_ok_o}, {15'h0, (c == 16'hB001)});
        for (int i = 0; i < 16; i++) send_bit(~c[i]);
        chk("R9", "16-bit residue", crc_o, 16'hB001);
        chk("R8", "16-bit residue flag", {15'h0, residue_ok_o}, 16'h1);
    endtask

    task automatic t_short5;
        logic [10:0] tok;
        logic [4:0]  c;
        tok = 11'h5A3;
        mode_short_i = 1'b1;
        poly_i = 16'h0014;
        residue_i = 16'hFF06;
        do_clear(16'h001F);
        chk("R7", "short preset view", crc_o, 16'h001F);
        for (int i = 0; i < 11; i++) send_bit(tok[i]);
        c = m5[4:0];
        chk("R7", "short remainder view", crc_o, {11'h0, c});
        for (int i = 0; i < 5; i++) send_bit(~c[i]);
        chk("R10", "5-bit residue", crc_o, 16'h0006);
        chk("R8", "masked 5-bit residue flag", {15'h0, residue_ok_o}, 16'h1);
        mode_short_i = 1'b0;
    endtask

    task automatic t_lanes;
        mode_short_i = 1'b0;
        poly_i = 16'hA014;
        do_clear(16'hFFFF);
        send_byte(8'h3C);
        chk("R11", "wide lane before mode change", crc_o, m16);
        mode_short_i = 1'b1;
        #1;
        chk("R11", "narrow lane saw every bit", crc_o, m5);
        mode_short_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_step();
        t_hold();
        t_clear_wins();
        t_vectors();
        t_residue16();
        t_short5();
        t_lanes();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule